// File: doc/BRIEF.md
# Incremental Encoder Up/Down Counter

This block counts the motion of an incremental encoder that delivers two square-wave tracks, A and B. Both tracks are first brought into the clock domain by a two-stage synchroniser and then cleaned by a run-length glitch filter. A three-bit source field selects how the filtered tracks drive the counter. In the two single-track modes, one track supplies the count edges (rising and falling alike) and the other track decides up or down. In full quadrature mode, every valid transition of either track is counted and the direction comes from their phase relation, so each step is a quarter of an encoder line. In any other mode, the counter steps once per clock in the direction that software selects.

The count runs between zero and a reload limit. Counting up past the limit restarts the count at zero. Counting down past zero loads the limit again. Either wrap gives a one-clock pulse and sets a sticky flag that software clears by writing a 1. The limit can be written directly. It can also be written through a shadow copy that takes effect only at the next wrap, so that the range can be changed without a partial period. All registers sit on a simple single-cycle write and combinational read bus.

Top module: `qenc_counter`

## Requirements
- R1: After synchronous reset, the registers read as follows: CTRL (0x00) = 0, SRC (0x04) = 0, FLAG (0x08) = 0 and COUNT (0x0C) = 0. RELOAD (0x10) reads 0xFFFF, and `wrap_pulse` is low.
- R2: With SRC = 1, each filtered edge of A moves the count by one. The count goes up when A differs from B after the edge and down otherwise. Edges of B alone leave the count unchanged.
- R3: With SRC = 2, each filtered edge of B moves the count by one. The count goes up when B equals A after the edge and down otherwise. Edges of A alone leave the count unchanged.
- R4: With SRC = 3, a change of A alone counts up when A differs from B after the change. A change of B alone counts up when B equals A after the change. Every other such change counts down.
- R5: With SRC = 3, a transition in which A and B change together does not change the count.
- R6: A level change on A or B that lasts 2 clocks or fewer is ignored. A change held for 12 clocks is counted (default filter length 4).
- R7: With SRC = 0 (and any value from 4 to 7), the enabled counter steps once per clock. It counts up when CTRL bit 1 is 0 and down when it is 1.
- R8: A step up from a count equal to the active limit gives 0, pulses `wrap_pulse` high for one clock and sets FLAG bit 0.
- R9: A step down from 0 loads the active limit, pulses `wrap_pulse` and sets FLAG bit 0.
- R10: With CTRL bit 2 clear, a RELOAD write changes the active limit at once. With CTRL bit 2 set, the write goes to a shadow copy, which becomes the active limit at the next wrap. RELOAD reads back the last written value.
- R11: Writing 1 to FLAG bit 0 clears it, and writing 0 does nothing. When a wrap and a clearing write fall in the same clock, the flag stays set.
- R12: A COUNT write takes priority over a step in the same clock. The written value is loaded exactly.
- R13: In SRC modes 1 to 3, CTRL bit 1 reads back the last decoded direction (1 = down), and software writes to it are ignored. In other modes it holds the written value.
- R14: With CTRL bit 0 (enable) clear, the count does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| enc_a | input | 1 | Encoder track A, asynchronous |
| enc_b | input | 1 | Encoder track B, asynchronous |
| wrap_pulse | output | 1 | One-clock pulse on every wrap |

## Verification
Two pairs of functions can meet in the same clock, and the bench provokes both in clock-count mode, where each step lands on a known edge. First, a write of 1 to the flag is timed onto the very edge on which the count passes from the limit to zero. The flag must read 1 afterwards and the count 0. Second, a COUNT write lands on an edge where a step is also due. The count must equal the written value, not that value plus or minus one.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_SRC  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_FLAG = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_RLD  = 5'h10;

    localparam int CTRL_EN  = 0;
    localparam int CTRL_DIR = 1;
    localparam int CTRL_PRE = 2;

    typedef enum logic [2:0] {
        SRC_CLOCK = 3'd0,
        SRC_A_CNT = 3'd1,
        SRC_B_CNT = 3'd2,
        SRC_QUAD  = 3'd3
    } src_e;

    typedef struct packed {
        logic step;
        logic up;
    } step_t;

    function automatic logic is_enc(input logic [2:0] m);
        return (m == SRC_A_CNT) || (m == SRC_B_CNT) || (m == SRC_QUAD);
    endfunction

endpackage

// File: rtl/qenc_filter.sv
module qenc_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            run_q  <= '0;
            filt_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], din};
            if (sync_q[1] != filt_q) begin
                if (run_q == CW'(FILT_LEN - 1)) begin
                    filt_q <= sync_q[1];
                    run_q  <= '0;
                end else begin
                    run_q <= run_q + CW'(1);
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign dout = filt_q;

    // R6: the filtered level only ever moves to the synchronised level
    assert_filter_follows_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> (filt_q == $past(sync_q[1])));

endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
    import qenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       a,
    input  logic       b,
    input  logic [2:0] src,
    input  logic       sw_dir,
    output step_t      st
);
    logic prev_a, prev_b;
    logic da, db;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
        end else begin
            prev_a <= a;
            prev_b <= b;
        end
    end

    assign da = a ^ prev_a;
    assign db = b ^ prev_b;

    always_comb begin
        case (src)
            SRC_A_CNT: begin
                st.step = da;
                st.up   = a ^ b;
            end
            SRC_B_CNT: begin
                st.step = db;
                st.up   = ~(a ^ b);
            end
            SRC_QUAD: begin
                st.step = da ^ db;
                st.up   = da ? (a ^ b) : ~(a ^ b);
            end
            default: begin
                st.step = 1'b1;
                st.up   = ~sw_dir;
            end
        endcase
    end

    // R5: a double change in quadrature mode never yields a step
    assert_double_change_R5: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_QUAD && da && db) |-> !st.step);

endmodule

// File: rtl/qenc_core.sv
module qenc_core
    import qenc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  step_t        st,
    input  logic         cnt_wr,
    input  logic         rl_wr,
    input  logic         preload,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic [W-1:0] shadow,
    output logic         hit,
    output logic         wrap
);
    logic [W-1:0] active;
    logic         adv;

    assign adv = en && st.step && !cnt_wr;
    assign hit = adv && (st.up ? (cnt == active) : (cnt == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= '1;
            shadow <= '1;
            wrap   <= 1'b0;
        end else begin
            wrap <= hit;
            if (cnt_wr) begin
                cnt <= wdata;
            end else if (adv) begin
                if (st.up) cnt <= (cnt == active) ? '0 : cnt + W'(1);
                else       cnt <= (cnt == '0) ? active : cnt - W'(1);
            end
            if (rl_wr) begin
                shadow <= wdata;
                if (!preload) active <= wdata;
            end
            if (hit && preload) active <= shadow;
        end
    end

    assert_wrap_up_R8: assert property (@(posedge clk) disable iff (rst)
        (en && st.step && st.up && !cnt_wr && cnt == active) |=> (cnt == '0 && wrap));

    assert_wrap_down_R9: assert property (@(posedge clk) disable iff (rst)
        (en && st.step && !st.up && !cnt_wr && cnt == '0) |=> (cnt == $past(active) && wrap));

    assert_sw_write_wins_R12: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == $past(wdata)));

    assert_hold_disabled_R14: assert property (@(posedge clk) disable iff (rst)
        (!en && !cnt_wr) |=> $stable(cnt));

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int W        = 16,
    parameter int FILT_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              enc_a,
    input  logic              enc_b,
    output logic              wrap_pulse
);
    logic [1:0] raw, filt;
    logic       en_q, dir_q, pre_q, flag_q;
    logic [2:0] src_q;
    step_t      st;
    logic [W-1:0] cnt, shadow;
    logic       hit;
    logic       wr_ctrl, wr_src, wr_flag, wr_cnt, wr_rld;

    assign raw = {enc_b, enc_a};

    for (genvar i = 0; i < 2; i++) begin : g_trk
        qenc_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk (clk),
            .rst (rst),
            .din (raw[i]),
            .dout(filt[i])
        );
    end

    qenc_decoder u_dec (
        .clk   (clk),
        .rst   (rst),
        .a     (filt[0]),
        .b     (filt[1]),
        .src   (src_q),
        .sw_dir(dir_q),
        .st    (st)
    );

    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_src  = bus_wr && (bus_addr == OFS_SRC);
    assign wr_flag = bus_wr && (bus_addr == OFS_FLAG);
    assign wr_cnt  = bus_wr && (bus_addr == OFS_CNT);
    assign wr_rld  = bus_wr && (bus_addr == OFS_RLD);

    qenc_core #(.W(W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .en     (en_q),
        .st     (st),
        .cnt_wr (wr_cnt),
        .rl_wr  (wr_rld),
        .preload(pre_q),
        .wdata  (bus_wdata),
        .cnt    (cnt),
        .shadow (shadow),
        .hit    (hit),
        .wrap   (wrap_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            dir_q  <= 1'b0;
            pre_q  <= 1'b0;
            src_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= bus_wdata[CTRL_EN];
                pre_q <= bus_wdata[CTRL_PRE];
                if (!is_enc(src_q)) dir_q <= bus_wdata[CTRL_DIR];
            end
            if (is_enc(src_q) && en_q && st.step) dir_q <= ~st.up;
            if (wr_src) src_q <= bus_wdata[2:0];
            if (wr_flag && bus_wdata[0]) flag_q <= 1'b0;
            if (hit) flag_q <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[CTRL_EN]  = en_q;
                bus_rdata[CTRL_DIR] = dir_q;
                bus_rdata[CTRL_PRE] = pre_q;
            end
            OFS_SRC:  bus_rdata[2:0] = src_q;
            OFS_FLAG: bus_rdata[0]   = flag_q;
            OFS_CNT:  bus_rdata      = cnt;
            OFS_RLD:  bus_rdata      = shadow;
            default:  bus_rdata      = '0;
        endcase
    end

    // R11: the flag is always set while the wrap pulse is out
    assert_flag_on_wrap_R11: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |-> flag_q);

    // R13: in encoder modes the direction bit follows the decoded step
    assert_hw_dir_R13: assert property (@(posedge clk) disable iff (rst)
        (is_enc(src_q) && en_q && st.step) |=> (dir_q == !$past(st.up)));

endmodule

// File: tb/qenc_counter_bench.sv
module qenc_counter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        enc_a = 1'b0, enc_b = 1'b0;
    logic        wrap_pulse;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    localparam logic [4:0] A_CTRL = 5'h00, A_SRC = 5'h04, A_FLAG = 5'h08,
                           A_CNT = 5'h0C, A_RLD = 5'h10;

    // {a, b, expected dir, expected count}
    localparam logic [9:0] QVEC [11] = '{
        {1'b1, 1'b0, 1'b0, 7'd1}, {1'b1, 1'b1, 1'b0, 7'd2},
        {1'b0, 1'b1, 1'b0, 7'd3}, {1'b0, 1'b0, 1'b0, 7'd4},
        {1'b1, 1'b1, 1'b0, 7'd4}, {1'b1, 1'b0, 1'b1, 7'd3},
        {1'b1, 1'b1, 1'b0, 7'd4}, {1'b0, 1'b1, 1'b0, 7'd5},
        {1'b1, 1'b1, 1'b1, 7'd4}, {1'b1, 1'b0, 1'b1, 7'd3},
        {1'b0, 1'b0, 1'b1, 7'd2}
    };

    always #5ns clk = ~clk;

    qenc_counter u_qenc_counter (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .enc_a(enc_a), .enc_b(enc_b), .wrap_pulse(wrap_pulse)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #1ns;
        d = bus_rdata;
    endtask

    task automatic set_ab(input logic a, input logic b);
        enc_a = a; enc_b = b;
        repeat (12) @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        wait_n(3);
        rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 16'h0);
        rd(A_SRC, v);  chk("R1 src", v, 16'h0);
        rd(A_FLAG, v); chk("R1 flag", v, 16'h0);
        rd(A_CNT, v);  chk("R1 count", v, 16'h0);
        rd(A_RLD, v);  chk("R1 reload", v, 16'hFFFF);
        chk("R1 pulse", {15'b0, wrap_pulse}, 16'h0);

        // R13 software direction in clock mode
        wr(A_CTRL, 16'h2);
        rd(A_CTRL, v); chk("R13 sw dir", v, 16'h2);
        wr(A_CTRL, 16'h0);

        // R7 / R8 up wrap in clock mode
        wr(A_RLD, 16'd5); wr(A_CNT, 16'd3); wr(A_CTRL, 16'h1);
        rd(A_CNT, v); chk("R7 start", v, 16'd3);
        wait_n(1); rd(A_CNT, v); chk("R7 step", v, 16'd4);
        wait_n(2); rd(A_CNT, v); chk("R8 wrap count", v, 16'd0);
        chk("R8 pulse high", {15'b0, wrap_pulse}, 16'h1);
        wait_n(1); chk("R8 pulse low", {15'b0, wrap_pulse}, 16'h0);
        wr(A_CTRL, 16'h0);
        rd(A_FLAG, v); chk("R8 flag", v, 16'h1);

        // R9 down wrap
        wr(A_CNT, 16'd1); wr(A_CTRL, 16'h3);
        wait_n(2); rd(A_CNT, v); chk("R9 reload", v, 16'd5);
        chk("R9 pulse", {15'b0, wrap_pulse}, 16'h1);
        wr(A_CTRL, 16'h0);

        // R11 wrap and clear in the same clock: set wins
        wr(A_CNT, 16'd4); wr(A_CTRL, 16'h1);
        wait_n(1);
        wr(A_FLAG, 16'h1);
        rd(A_FLAG, v); chk("R11 set wins", v, 16'h1);
        rd(A_CNT, v);  chk("R11 count wrapped", v, 16'd0);
        wr(A_CTRL, 16'h0);
        wr(A_FLAG, 16'h0); rd(A_FLAG, v); chk("R11 write0", v, 16'h1);
        wr(A_FLAG, 16'h1); rd(A_FLAG, v); chk("R11 clear", v, 16'h0);

        // R12 software write against a step
        wr(A_CNT, 16'd2); wr(A_CTRL, 16'h1);
        wr(A_CNT, 16'd1);
        rd(A_CNT, v); chk("R12 write wins", v, 16'd1);
        wait_n(1); rd(A_CNT, v); chk("R12 resumes", v, 16'd2);
        wr(A_CTRL, 16'h0);

        // R10 buffered limit
        wr(A_CTRL, 16'h4); wr(A_CNT, 16'd4); wr(A_RLD, 16'd8);
        rd(A_RLD, v); chk("R10 readback", v, 16'd8);
        wr(A_CTRL, 16'h5);
        wait_n(2); rd(A_CNT, v); chk("R10 old limit", v, 16'd0);
        wait_n(6); rd(A_CNT, v); chk("R10 new limit", v, 16'd6);
        wr(A_CTRL, 16'h0);
        wr(A_RLD, 16'd3); wr(A_CNT, 16'd2); wr(A_CTRL, 16'h1);
        wait_n(2); rd(A_CNT, v); chk("R10 immediate", v, 16'd0);
        wr(A_CTRL, 16'h0);

        // R2 A counts, B steers
        wr(A_RLD, 16'd100); wr(A_SRC, 16'd1); wr(A_CNT, 16'd10); wr(A_CTRL, 16'h1);
        set_ab(1'b0, 1'b1); rd(A_CNT, v); chk("R2 B ignored", v, 16'd10);
        set_ab(1'b1, 1'b1); rd(A_CNT, v); chk("R2 rise down", v, 16'd9);
        set_ab(1'b0, 1'b1); rd(A_CNT, v); chk("R2 fall up", v, 16'd10);
        set_ab(1'b0, 1'b0); rd(A_CNT, v); chk("R2 B ignored2", v, 16'd10);
        set_ab(1'b1, 1'b0); rd(A_CNT, v); chk("R2 rise up", v, 16'd11);

        // R3 B counts, A steers
        wr(A_SRC, 16'd2); wr(A_CNT, 16'd20);
        set_ab(1'b0, 1'b0); rd(A_CNT, v); chk("R3 A ignored", v, 16'd20);
        set_ab(1'b0, 1'b1); rd(A_CNT, v); chk("R3 rise down", v, 16'd19);
        set_ab(1'b1, 1'b1); rd(A_CNT, v); chk("R3 A ignored2", v, 16'd19);
        set_ab(1'b1, 1'b0); rd(A_CNT, v); chk("R3 fall down", v, 16'd18);
        set_ab(1'b1, 1'b1); rd(A_CNT, v); chk("R3 rise up", v, 16'd19);

        // R4 / R5 quadrature vector table
        wr(A_CTRL, 16'h0);
        set_ab(1'b0, 1'b0);
        wr(A_SRC, 16'd3); wr(A_CNT, 16'd0); wr(A_CTRL, 16'h1);
        for (int i = 0; i < 11; i++) begin
            set_ab(QVEC[i][9], QVEC[i][8]);
            rd(A_CNT, v);  chk("R4 R5 quad count", v, {9'b0, QVEC[i][6:0]});
            rd(A_CTRL, v); chk("R13 quad dir", {15'b0, v[1]}, {15'b0, QVEC[i][7]});
        end

        // R13 software write of direction ignored in encoder mode
        wr(A_CTRL, 16'h1);
        rd(A_CTRL, v); chk("R13 hw dir kept", v, 16'h3);

        // R6 glitch rejected
        enc_a = 1'b1; wait_n(2); enc_a = 1'b0; wait_n(12);
        rd(A_CNT, v); chk("R6 glitch", v, 16'd2);

        // R14 disabled counter holds
        wr(A_CTRL, 16'h0);
        set_ab(1'b1, 1'b0);
        rd(A_CNT, v); chk("R14 hold", v, 16'd2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule